// File: doc/BRIEF.md
# Configuration Space Access Port

This block lets a host reach the configuration registers of the devices on one local bus through two 32-bit register words. The host first writes an address word that names a bus, a device, a function and a dword register. It then reads or writes the second word, the data window. The block splits the address word into its fields. When the named bus is the local one and the enable bit is set, it presents one configuration request to the local device side and holds it there until that side answers. Any other data-window access finishes at once: a read returns all ones and a write is dropped.

The local bus number is an input, so the same block can serve any bus position. Whether an address targets this bus is decided at the moment the address word is written. The host side has a ready signal, and data-window accesses stall on it until the device side has answered.

Top module: `cfg_access_port`

## Requirements
- R1: An access to the address port (host_word = 0) completes in the cycle it is presented (host_ready = 1). A write stores each byte whose host_be bit is set, with bits 1:0 of the stored word always 0. A read returns the stored word.
- R2: The stored address word is split into fields: bus number in bits 23:16, device in bits 15:11, function in bits 10:8, and dword register in bits 7:2. Bit 31 is the enable bit. Bits 30:24 are ignored.
- R3: The target counts as on the local bus only if the bus field of the word just written equals local_bus at the clock edge that stores it. A later change of local_bus has no effect until the next address write.
- R4: A data-port access (host_word = 1) whose target is not on the local bus, or whose enable bit is 0, issues no request and completes in the cycle it is presented. A read of that kind returns 0xFFFFFFFF, and a write of that kind is discarded.
- R5: A data-port access to a valid target raises dev_req at the next clock edge. dev_dev, dev_func and dev_reg then carry the latched device, the latched function and the low address byte masked with 0xFC.
- R6: With each request, dev_we follows host_we, dev_wdata carries host_wdata, and dev_mask carries host_be unchanged. All request outputs stay stable while dev_req waits for dev_ack.
- R7: dev_req stays high until dev_ack is sampled high. host_ready is high in the cycle dev_ack is high, and for a read host_rdata equals dev_rdata in that cycle. dev_req is low at the next edge.
- R8: After reset the address word is 0, the target is invalid and dev_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access valid; held until host_ready |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_word | input | 1 | Word select: 0 = address port, 1 = data port |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte enables |
| host_rdata | output | 32 | Host read data, valid with host_ready |
| host_ready | output | 1 | Host access completes this cycle |
| local_bus | input | 8 | Bus number of the local bus |
| dev_req | output | 1 | Configuration request pending |
| dev_we | output | 1 | Request direction, 1 = write |
| dev_dev | output | 5 | Target device number |
| dev_func | output | 3 | Target function number |
| dev_reg | output | 8 | Register byte offset, low two bits 0 |
| dev_wdata | output | 32 | Write data for the request |
| dev_mask | output | 4 | Byte mask for the request |
| dev_ack | input | 1 | Device response handshake |
| dev_rdata | input | 32 | Device read data, valid with dev_ack |

## Verification
On every cycle, the assertions check the device-side handshake. A pending request holds and keeps its fields steady until acknowledged. The acknowledge cycle completes the host access. A request can only rise after the target was judged valid, and no address-port access overlaps a pending request. Only the bench scenarios can show the decode itself: that each field lands on the right output for varied address words, that the bus match is frozen at address-write time, that byte-enabled partial address writes merge correctly, and that dropped accesses return all ones with no request.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  localparam int unsigned CFG_DATA_W = 32;
  localparam int unsigned CFG_BUS_W  = 8;
  localparam int unsigned CFG_DEV_W  = 5;
  localparam int unsigned CFG_FUNC_W = 3;
  localparam int unsigned CFG_REG_W  = 8;
  localparam int unsigned CFG_LOW_ZERO = 2;

  typedef enum logic [0:0] {
    CTL_IDLE = 1'b0,
    CTL_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cfg_addr_latch.sv
`timescale 1ns/1ps
module cfg_addr_latch #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BE_W     = DATA_W / 8,
  parameter int unsigned LOW_ZERO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] addr_next
);
  localparam logic [DATA_W-1:0] LOW_MASK =
    {{(DATA_W-LOW_ZERO){1'b0}}, {LOW_ZERO{1'b1}}};

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [BE_W-1:0]   en
  );
    logic [DATA_W-1:0] m;
    m = old_w;
    for (int b = 0; b < BE_W; b++) begin
      if (en[b]) m[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] align_word(input logic [DATA_W-1:0] w);
    return w & ~LOW_MASK;
  endfunction

  assign addr_next = align_word(merge_bytes(addr_q, wdata, be));

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= addr_next;
  end
endmodule

// File: rtl/cfg_target_sel.sv
`timescale 1ns/1ps
module cfg_target_sel #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned DEV_W    = 5,
  parameter int unsigned FUNC_W   = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned LOW_ZERO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] addr_next,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [BUS_W-1:0]  local_bus,
  output logic              tgt_ok,
  output logic [DEV_W-1:0]  tgt_dev,
  output logic [FUNC_W-1:0] tgt_func,
  output logic [REG_W-1:0]  tgt_reg
);
  localparam int unsigned FUNC_LSB = REG_W;
  localparam int unsigned DEV_LSB  = FUNC_LSB + FUNC_W;
  localparam int unsigned BUS_LSB  = DEV_LSB + DEV_W;
  localparam int unsigned TOP_USED = BUS_LSB + BUS_W;
  localparam int unsigned EN_BIT   = DATA_W - 1;
  localparam logic [REG_W-1:0] REG_MASK =
    ~{{(REG_W-LOW_ZERO){1'b0}}, {LOW_ZERO{1'b1}}};

  function automatic logic [BUS_W-1:0] bus_field(input logic [DATA_W-1:0] w);
    return w[BUS_LSB +: BUS_W];
  endfunction

  function automatic logic [REG_W-1:0] reg_field(input logic [DATA_W-1:0] w);
    return w[REG_W-1:0] & REG_MASK;
  endfunction

  logic match_q;
  logic unused_reserved;

  always_ff @(posedge clk) begin
    if (!rst_n)      match_q <= 1'b0;
    else if (wr_evt) match_q <= (bus_field(addr_next) == local_bus);
  end

  assign tgt_ok   = match_q & addr_q[EN_BIT];
  assign tgt_dev  = addr_q[DEV_LSB +: DEV_W];
  assign tgt_func = addr_q[FUNC_LSB +: FUNC_W];
  assign tgt_reg  = reg_field(addr_q);
  assign unused_reserved = ^{addr_q[EN_BIT-1:TOP_USED], addr_next[EN_BIT:TOP_USED],
                             addr_next[BUS_LSB-1:0]};
endmodule

// File: rtl/cfg_req_ctrl.sv
`timescale 1ns/1ps
module cfg_req_ctrl
  import cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = DATA_W / 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FUNC_W = 3,
  parameter int unsigned REG_W  = 8,
  parameter logic [DATA_W-1:0] INVALID_RD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_sel,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [BE_W-1:0]   host_be,
  input  logic              tgt_ok,
  input  logic [DEV_W-1:0]  tgt_dev,
  input  logic [FUNC_W-1:0] tgt_func,
  input  logic [REG_W-1:0]  tgt_reg,
  output logic              data_ready,
  output logic [DATA_W-1:0] data_rdata,
  output logic              dev_req,
  output logic              dev_we,
  output logic [DEV_W-1:0]  dev_dev,
  output logic [FUNC_W-1:0] dev_func,
  output logic [REG_W-1:0]  dev_reg,
  output logic [DATA_W-1:0] dev_wdata,
  output logic [BE_W-1:0]   dev_mask,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata
);
  ctl_state_e state_q, state_d;
  logic       launch;
  logic       drop;
  logic       finish;

  assign launch = (state_q == CTL_IDLE) && data_sel && tgt_ok;
  assign drop   = (state_q == CTL_IDLE) && data_sel && !tgt_ok;
  assign finish = (state_q == CTL_WAIT) && dev_ack;

  always_comb begin
    state_d = state_q;
    if (launch)      state_d = CTL_WAIT;
    else if (finish) state_d = CTL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= CTL_IDLE;
      dev_we    <= 1'b0;
      dev_dev   <= '0;
      dev_func  <= '0;
      dev_reg   <= '0;
      dev_wdata <= '0;
      dev_mask  <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        dev_we    <= host_we;
        dev_dev   <= tgt_dev;
        dev_func  <= tgt_func;
        dev_reg   <= tgt_reg;
        dev_wdata <= host_wdata;
        dev_mask  <= host_be;
      end
    end
  end

  assign dev_req    = (state_q == CTL_WAIT);
  assign data_ready = drop || finish;
  assign data_rdata = finish ? dev_rdata : INVALID_RD;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_ack |=> dev_req);

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && dev_ack |=> !dev_req);

  assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_ack |=> $stable({dev_we, dev_dev, dev_func, dev_reg, dev_wdata, dev_mask}));

  assert_ready_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && dev_ack |-> data_ready && (data_rdata == dev_rdata));

  assert_no_req_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req) |-> $past(tgt_ok && data_sel));
endmodule

// File: rtl/cfg_access_port.sv
`timescale 1ns/1ps
module cfg_access_port
  import cfg_pkg::*;
#(
  parameter int unsigned DATA_W = CFG_DATA_W,
  parameter int unsigned BUS_W  = CFG_BUS_W,
  parameter int unsigned DEV_W  = CFG_DEV_W,
  parameter int unsigned FUNC_W = CFG_FUNC_W,
  parameter int unsigned REG_W  = CFG_REG_W,
  parameter int unsigned LOW_ZERO = CFG_LOW_ZERO,
  parameter logic [DATA_W-1:0] INVALID_RD = '1,
  localparam int unsigned BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic              host_word,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [BE_W-1:0]   host_be,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  input  logic [BUS_W-1:0]  local_bus,
  output logic              dev_req,
  output logic              dev_we,
  output logic [DEV_W-1:0]  dev_dev,
  output logic [FUNC_W-1:0] dev_func,
  output logic [REG_W-1:0]  dev_reg,
  output logic [DATA_W-1:0] dev_wdata,
  output logic [BE_W-1:0]   dev_mask,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata
);
  logic              addr_wr_evt;
  logic              data_sel;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] addr_next;
  logic              tgt_ok;
  logic [DEV_W-1:0]  tgt_dev;
  logic [FUNC_W-1:0] tgt_func;
  logic [REG_W-1:0]  tgt_reg;
  logic              data_ready;
  logic [DATA_W-1:0] data_rdata;

  assign addr_wr_evt = host_sel && !host_word && host_we;
  assign data_sel    = host_sel && host_word;

  cfg_addr_latch #(.DATA_W(DATA_W), .BE_W(BE_W), .LOW_ZERO(LOW_ZERO)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr_evt), .wdata(host_wdata),
    .be(host_be), .addr_q(addr_q), .addr_next(addr_next)
  );

  cfg_target_sel #(.DATA_W(DATA_W), .BUS_W(BUS_W), .DEV_W(DEV_W),
                   .FUNC_W(FUNC_W), .REG_W(REG_W), .LOW_ZERO(LOW_ZERO)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_evt(addr_wr_evt), .addr_next(addr_next),
    .addr_q(addr_q), .local_bus(local_bus), .tgt_ok(tgt_ok),
    .tgt_dev(tgt_dev), .tgt_func(tgt_func), .tgt_reg(tgt_reg)
  );

  cfg_req_ctrl #(.DATA_W(DATA_W), .BE_W(BE_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
                 .REG_W(REG_W), .INVALID_RD(INVALID_RD)) u_ctl (
    .clk(clk), .rst_n(rst_n), .data_sel(data_sel), .host_we(host_we),
    .host_wdata(host_wdata), .host_be(host_be), .tgt_ok(tgt_ok),
    .tgt_dev(tgt_dev), .tgt_func(tgt_func), .tgt_reg(tgt_reg),
    .data_ready(data_ready), .data_rdata(data_rdata),
    .dev_req(dev_req), .dev_we(dev_we), .dev_dev(dev_dev), .dev_func(dev_func),
    .dev_reg(dev_reg), .dev_wdata(dev_wdata), .dev_mask(dev_mask),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );

  assign host_ready = host_word ? data_ready : host_sel;
  assign host_rdata = host_word ? data_rdata : addr_q;

  assert_addr_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && !host_word |-> !dev_req);

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |=> !dev_req);
endmodule

// File: tb/cfg_access_port_tb_top.sv
`timescale 1ns/1ps
module cfg_access_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_we = 1'b0, host_word = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_rdata;
  logic        host_ready;
  logic [7:0]  local_bus = '0;
  logic        dev_req, dev_we;
  logic [4:0]  dev_dev;
  logic [2:0]  dev_func;
  logic [7:0]  dev_reg;
  logic [31:0] dev_wdata;
  logic [3:0]  dev_mask;
  logic        dev_ack = 1'b0;
  logic [31:0] dev_rdata = '0;

  always #5 clk = ~clk;

  cfg_access_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_word(host_word), .host_wdata(host_wdata), .host_be(host_be),
    .host_rdata(host_rdata), .host_ready(host_ready), .local_bus(local_bus),
    .dev_req(dev_req), .dev_we(dev_we), .dev_dev(dev_dev), .dev_func(dev_func),
    .dev_reg(dev_reg), .dev_wdata(dev_wdata), .dev_mask(dev_mask),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // results of the last access
  logic [31:0] acc_rdata;
  bit          acc_req;
  logic        cap_we;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_func;
  logic [7:0]  cap_reg;
  logic [31:0] cap_wdata;
  logic [3:0]  cap_mask;
  int          acc_cycles;

  task automatic access(input logic we, input logic word, input logic [31:0] wd,
                        input logic [3:0] be, input int delay);
    int waited = 0;
    bit fin = 0;
    acc_req = 0; acc_cycles = 0;
    @(negedge clk);
    host_sel = 1; host_we = we; host_word = word; host_wdata = wd; host_be = be;
    while (!fin) begin
      #1;
      if (dev_req) begin
        acc_req = 1;
        cap_we = dev_we; cap_dev = dev_dev; cap_func = dev_func;
        cap_reg = dev_reg; cap_wdata = dev_wdata; cap_mask = dev_mask;
        if (waited >= delay) begin
          dev_ack = 1;
          dev_rdata = 32'hC0DE_0000 | {16'h0, dev_dev, dev_func, dev_reg};
        end
        waited++;
      end
      #1;
      if (host_ready) begin
        acc_rdata = host_rdata;
        fin = 1;
      end else begin
        acc_cycles++;
        if (acc_cycles > 50) fin = 1;
        @(negedge clk);
      end
    end
    @(posedge clk);
    #1;
    host_sel = 0; dev_ack = 0;
  endtask

  // vector: {local_bus, address word, expected target valid}
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {8'h00, 32'h8000_0800, 1'b1},
    {8'h00, 32'h8001_0000, 1'b0},
    {8'h01, 32'h8001_F7FC, 1'b1},
    {8'h01, 32'h0001_0800, 1'b0},
    {8'h5A, 32'h805A_1A47, 1'b1},
    {8'hFF, 32'h80FE_0000, 1'b0}
  };

  function automatic logic [31:0] exp_dev(input logic [31:0] a);  return (a / 2048) % 32; endfunction
  function automatic logic [31:0] exp_func(input logic [31:0] a); return (a / 256) % 8; endfunction
  function automatic logic [31:0] exp_reg(input logic [31:0] a);  return ((a % 256) / 4) * 4; endfunction
  function automatic logic [31:0] exp_resp(input logic [31:0] a);
    return 32'hC0DE_0000 + exp_dev(a) * 2048 + exp_func(a) * 256 + exp_reg(a);
  endfunction

  task automatic data_pair(input string tag, input logic [31:0] a, input bit ok, input int delay);
    // read
    access(1'b0, 1'b1, 32'h0, 4'b0110, delay);
    check({tag, " R5 read request issued"}, 32'(acc_req), 32'(ok));
    if (ok) begin
      check({tag, " R5 dev"},  32'(cap_dev),  exp_dev(a));
      check({tag, " R5 func"}, 32'(cap_func), exp_func(a));
      check({tag, " R5 reg"},  32'(cap_reg),  exp_reg(a));
      check({tag, " R6 read dir"}, 32'(cap_we), 32'h0);
      check({tag, " R6 mask"}, 32'(cap_mask), 32'h6);
      check({tag, " R7 rdata"}, acc_rdata, exp_resp(a));
      check({tag, " R7 stall cycles"}, 32'(acc_cycles), 32'(delay + 1));
    end else begin
      check({tag, " R4 invalid read"}, acc_rdata, 32'hFFFF_FFFF);
      check({tag, " R4 no stall"}, 32'(acc_cycles), 32'h0);
    end
    check({tag, " R7 req cleared"}, 32'(dev_req), 32'h0);
    // write
    access(1'b1, 1'b1, ~a, 4'b1010, delay + 1);
    check({tag, " R5 write request issued"}, 32'(acc_req), 32'(ok));
    if (ok) begin
      check({tag, " R6 write dir"},  32'(cap_we), 32'h1);
      check({tag, " R6 write data"}, cap_wdata, ~a);
      check({tag, " R6 write mask"}, 32'(cap_mask), 32'hA);
      check({tag, " R5 write reg"},  32'(cap_reg), exp_reg(a));
    end
    check({tag, " R7 req cleared after write"}, 32'(dev_req), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 dev_req in reset", 32'(dev_req), 32'h0);
    rst_n = 1;
    // R8: reset state
    access(1'b0, 1'b0, 32'h0, 4'hF, 0);
    check("R8 address word after reset", acc_rdata, 32'h0);
    access(1'b0, 1'b1, 32'h0, 4'hF, 0);
    check("R8 target invalid after reset", acc_rdata, 32'hFFFF_FFFF);
    check("R8 no request after reset", 32'(acc_req), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  lb;
      logic [31:0] a;
      logic [31:0] stored;
      bit ok;
      lb = VEC[i][40:33]; a = VEC[i][32:1]; ok = VEC[i][0];
      stored = a - (a % 4);
      local_bus = lb;
      access(1'b1, 1'b0, a, 4'hF, 0);
      check("R1 address write immediate", 32'(acc_cycles), 32'h0);
      access(1'b0, 1'b0, 32'h0, 4'hF, 0);
      check("R1 address readback", acc_rdata, stored);
      data_pair($sformatf("vec%0d R2 R3", i), stored, ok, i % 3);
    end

    // R1/R3: partial byte-enable address write
    local_bus = 8'h00;
    access(1'b1, 1'b0, 32'h8000_0800, 4'hF, 0);
    access(1'b1, 1'b0, 32'h1203_5678, 4'b0100, 0);
    access(1'b0, 1'b0, 32'h0, 4'hF, 0);
    check("R1 byte-enable merge", acc_rdata, 32'h8003_0800);
    access(1'b0, 1'b1, 32'h0, 4'hF, 0);
    check("R3 merged bus mismatch read", acc_rdata, 32'hFFFF_FFFF);
    check("R3 merged bus mismatch no req", 32'(acc_req), 32'h0);
    // R3: local_bus change after the write has no effect
    local_bus = 8'h03;
    access(1'b0, 1'b1, 32'h0, 4'hF, 0);
    check("R3 late local_bus change ignored", acc_rdata, 32'hFFFF_FFFF);
    check("R3 late local_bus no req", 32'(acc_req), 32'h0);
    access(1'b1, 1'b0, 32'h0000_0000, 4'b0001, 0);
    data_pair("R3 rewrite matches", 32'h8003_0800, 1'b1, 2);
    // R3: match frozen valid even if local_bus moves away
    local_bus = 8'h07;
    data_pair("R3 valid frozen", 32'h8003_0800, 1'b1, 0);
    // R4: enable bit cleared by byte write keeps the bus match but drops access
    access(1'b1, 1'b0, 32'h0000_0000, 4'b1000, 0);
    local_bus = 8'h03;
    access(1'b1, 1'b0, 32'h0000_0000, 4'b1000, 0);
    data_pair("R4 enable clear", 32'h0003_0800, 1'b0, 0);

    finish_run();
  end
endmodule